// File: doc/BRIEF.md
# Multicart Outer Bank Extension

This block widens the page numbers produced by an existing cartridge bank-switching controller so that one board can hold many small games. The CPU writes into the window from $6000 to $7FFF. Each of those writes lands in one of four 8-bit outer registers. Two of the registers then decide, for every program page number and every pattern page number that the inner controller produces, which bits the inner controller keeps and which bits come from a fixed outer base. The results are a 12-bit program bank, counted in 8 KiB pages and used for the $8000–$FFFF area, and an 8-bit pattern bank, counted in 1 KiB pages.

One encoding in the fourth register freezes all four registers until the next reset, so that a menu program can hand the cartridge over to a game that cannot leave it. Window writes still reach work RAM while the inner controller has that RAM enabled, and the block tells the memory side about each such write with a forwarding flag. The block does not hold the inner controller, the interrupt logic, the mirroring control or any memory.

Top module: `outer_bank_ext`

## Requirements
- R1: A write strobe with an address whose top three bits are 011 ($6000–$7FFF) stores the data byte in outer register number addr[1:0]. The store takes effect at the clock edge that ends the strobe cycle. All other address bits inside the window are ignored, so $7FFD writes register 1.
- R2: The registers are frozen while register 3 ANDed with 0x90 equals 0x80. A frozen register file ignores every window write, including writes to register 3, until reset. The test uses the register 3 value from before the current write, so the write that stores 0x80 into register 3 itself succeeds. A value such as 0x90 does not freeze the registers.
- R3: A write whose address lies outside $6000–$7FFF, either below $6000 or at $8000 and above, never changes any outer register.
- R4: During a strobe cycle, `wram_wr` is 1 exactly when the address is in the window and `ram_en` is 1. This holds whether or not the registers are frozen. `wram_wr` is 0 when there is no strobe.
- R5: The program mask M is a 12-bit value. Bits 11:8 are 0. Bits 3:0 are 1. Bit 4 is NOT r0[6]. Bit 5 is NOT r1[7]. Bit 6 is r1[6]. Bit 7 is r1[5].
- R6: The program base B is an 8-bit value. B[2:0] = r0[2:0], B[3] = r1[4], B[5:4] = r1[3:2] and B[7:6] = r0[5:4]. The program bank is ((B·16) AND NOT M) OR (inner page AND M), computed at 12 bits with nothing truncated.
- R7: The pattern bank takes bit 7 from r0[3] when r0[7] is 1, and from the inner page when r0[7] is 0. Bits 6:0 always come from the inner pattern page.
- R8: Reset clears all four registers and removes the freeze. After reset the program bank equals the inner page AND 0x3F, and the pattern bank equals the inner pattern page.
- R9: Both bank outputs follow the inner page inputs and the current register values combinationally. During a write strobe, before the closing edge, they still reflect the old register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU address of the write |
| cpu_wdata | input | 8 | CPU write data |
| ram_en | input | 1 | Work RAM enable taken from the inner controller |
| prg_inner | input | 8 | Inner 8 KiB program page number |
| chr_inner | input | 8 | Inner 1 KiB pattern page number |
| prg_bank | output | 12 | Final program bank |
| chr_bank | output | 8 | Final pattern bank |
| wram_wr | output | 1 | The current window write is also a work RAM write |

## Verification
Two functions meet in the same cycle: a window write that the freeze must drop, and the work RAM forwarding flag, which must stay up for that same write. The bench freezes the registers by writing 0x80 to register 3. It then strobes window writes with `ram_en` set, and also with it cleared. For each strobe it checks that the forwarding flag follows `ram_en`, while the bank outputs show that the dropped write changed nothing. A second collision covers the write that creates the freeze: it must still land in register 3, and only the writes after it are dropped.

// File: rtl/obx_pkg.sv
package obx_pkg;
  localparam int unsigned REG_W      = 8;
  localparam int unsigned NUM_REGS   = 4;
  localparam int unsigned ADDR_W     = 16;
  localparam int unsigned PRG_IN_W   = 8;
  localparam int unsigned PRG_OUT_W  = 12;
  localparam int unsigned CHR_W      = 8;
  localparam int unsigned BASE_SHIFT = 4;
  localparam int unsigned SEL_W      = $clog2(NUM_REGS);
  localparam logic [2:0]  WIN_TAG    = 3'b011;
  localparam int unsigned FREEZE_IDX = 3;
  localparam logic [REG_W-1:0] FREEZE_MASK = 8'h90;
  localparam logic [REG_W-1:0] FREEZE_VAL  = 8'h80;

  typedef logic [NUM_REGS-1:0][REG_W-1:0] reg_file_t;
endpackage

// File: rtl/obx_regfile.sv
module obx_regfile
  import obx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  output reg_file_t         regs_o,
  output logic              win_hit_o
);
  reg_file_t            q;
  logic                 frozen;
  logic                 accept;
  logic [NUM_REGS-1:0]  en;

  assign win_hit_o = wr_stb && (wr_addr[ADDR_W-1:ADDR_W-3] == WIN_TAG);
  assign frozen    = (q[FREEZE_IDX] & FREEZE_MASK) == FREEZE_VAL;
  assign accept    = win_hit_o && !frozen;

  logic unused_addr;
  assign unused_addr = ^wr_addr[ADDR_W-4:SEL_W];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_comb begin
      en[i] = accept && (wr_addr[SEL_W-1:0] == SEL_W'(i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q[i] <= '0;
      end else if (en[i]) begin
        q[i] <= wr_data;
      end
    end

    assert_reg_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (win_hit_o && !frozen && wr_addr[SEL_W-1:0] == SEL_W'(i)) |=> (q[i] == $past(wr_data)))
      else $error("R1 store lost");
  end

  assign regs_o = q;

  assert_freeze_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> (frozen && $stable(q)))
    else $error("R2 frozen file changed");

  assert_outside_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !win_hit_o |=> $stable(q))
    else $error("R3 register moved without window write");
endmodule

// File: rtl/obx_prg_map.sv
module obx_prg_map
  import obx_pkg::*;
(
  input  logic [REG_W-1:0]     r0,
  input  logic [REG_W-1:0]     r1,
  input  logic [PRG_IN_W-1:0]  inner,
  output logic [PRG_OUT_W-1:0] bank
);
  logic [PRG_OUT_W-1:0] mask;
  logic [REG_W-1:0]     base;
  logic [PRG_OUT_W-1:0] base_sh;
  logic [PRG_OUT_W-1:0] inner_x;

  always_comb begin
    mask      = '0;
    mask[5:0] = 6'h3F;
    mask[6]   = r1[6];
    mask[7]   = r1[5];
    mask[4]   = mask[4] ^ r0[6];
    mask[5]   = mask[5] ^ r1[7];
  end

  always_comb begin
    base[2:0] = r0[2:0];
    base[3]   = r1[4];
    base[5:4] = r1[3:2];
    base[7:6] = r0[5:4];
  end

  assign base_sh = PRG_OUT_W'(base) << BASE_SHIFT;
  assign inner_x = PRG_OUT_W'(inner);
  assign bank    = (base_sh & ~mask) | (inner_x & mask);

  logic unused_bits;
  assign unused_bits = ^{r0[7], r0[3], r1[1:0]};
endmodule

// File: rtl/obx_chr_map.sv
module obx_chr_map
  import obx_pkg::*;
(
  input  logic [REG_W-1:0] r0,
  input  logic [CHR_W-1:0] inner,
  output logic [CHR_W-1:0] bank
);
  logic [CHR_W-1:0] mask;
  logic [CHR_W-1:0] fill;

  assign mask = {CHR_W{1'b1}} ^ {r0[7], {(CHR_W-1){1'b0}}};
  assign fill = {r0[3], {(CHR_W-1){1'b0}}};
  assign bank = (inner & mask) | (fill & ~mask);

  logic unused_bits;
  assign unused_bits = ^{r0[6:4], r0[2:0]};
endmodule

// File: rtl/outer_bank_ext.sv
module outer_bank_ext
  import obx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpu_wr,
  input  logic [ADDR_W-1:0]    cpu_addr,
  input  logic [REG_W-1:0]     cpu_wdata,
  input  logic                 ram_en,
  input  logic [PRG_IN_W-1:0]  prg_inner,
  input  logic [CHR_W-1:0]     chr_inner,
  output logic [PRG_OUT_W-1:0] prg_bank,
  output logic [CHR_W-1:0]     chr_bank,
  output logic                 wram_wr
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  reg_file_t  regs;
  logic       win_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  obx_regfile u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_stb    (cpu_wr),
    .wr_addr   (cpu_addr),
    .wr_data   (cpu_wdata),
    .regs_o    (regs),
    .win_hit_o (win_hit)
  );

  obx_prg_map u_prg (
    .r0    (regs[0]),
    .r1    (regs[1]),
    .inner (prg_inner),
    .bank  (prg_bank)
  );

  obx_chr_map u_chr (
    .r0    (regs[0]),
    .inner (chr_inner),
    .bank  (chr_bank)
  );

  assign wram_wr = win_hit && ram_en;

  logic unused_regs;
  assign unused_regs = ^regs[2];

  assert_clear_state_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (regs == '0) |-> ((prg_bank == PRG_OUT_W'(prg_inner & 8'h3F)) && (chr_bank == chr_inner)))
    else $error("R8 cleared state does not pass inner pages");
endmodule

// File: tb/outer_bank_ext_tb.sv
module outer_bank_ext_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_wr;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        ram_en;
  logic [7:0]  prg_inner;
  logic [7:0]  chr_inner;
  logic [11:0] prg_bank;
  logic [7:0]  chr_bank;
  logic        wram_wr;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  outer_bank_ext u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .ram_en(ram_en), .prg_inner(prg_inner),
    .chr_inner(chr_inner), .prg_bank(prg_bank), .chr_bank(chr_bank),
    .wram_wr(wram_wr)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_prg(input int r0, input int r1, input int pg);
    int m, b;
    m = 'h0F;
    if ((r0 & 'h40) == 0) m = m + 'h10;
    if ((r1 & 'h80) == 0) m = m + 'h20;
    if ((r1 & 'h40) != 0) m = m + 'h40;
    if ((r1 & 'h20) != 0) m = m + 'h80;
    b = (r0 % 8) + (((r1 / 16) % 2) * 8) + (((r1 / 4) % 4) * 16) + (((r0 / 16) % 4) * 64);
    return ((b * 16) & ~m & 'hFFF) | (pg & m);
  endfunction

  function automatic int exp_chr(input int r0, input int pg);
    if ((r0 & 'h80) != 0) return (pg % 128) + (((r0 / 8) % 2) * 128);
    return pg;
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = 16'(a); cpu_wdata = 8'(d);
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic sweep(input string req, input int r0, input int r1);
    for (int p = 0; p < 256; p += 5) begin
      prg_inner = 8'(p); chr_inner = 8'(255 - p);
      #1;
      chk(req, int'(prg_bank), exp_prg(r0, r1, p));
      chk("R7", int'(chr_bank), exp_chr(r0, 255 - p));
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        n_bad++; n_chk++;
        $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    int vals[4];
    cpu_wr = 0; cpu_addr = 0; cpu_wdata = 0; ram_en = 0;
    prg_inner = 0; chr_inner = 0;
    do_reset();

    // R8: cleared state
    sweep("R8", 0, 0);

    // R5 R6 R1: sweep reg0 with a few reg1 values, alias addresses
    vals = '{'h00, 'h3C, 'hE0, 'hFF};
    foreach (vals[k]) begin
      wr('h7FF1, vals[k]);
      for (int a = 0; a < 256; a++) begin
        wr('h6F04, a);
        sweep("R5", a, vals[k]);
      end
    end
    // reg1 sweep with a few reg0 values
    vals = '{'h00, 'h77, 'h48, 'hFF};
    foreach (vals[k]) begin
      wr('h6000, vals[k]);
      for (int b = 0; b < 256; b++) begin
        wr('h7001, b);
        sweep("R6", vals[k], b);
      end
    end

    // R1: register 2 writes leave banks alone
    wr('h6000, 'h00); wr('h6001, 'h00);
    wr('h6002, 'hFF);
    sweep("R1", 0, 0);

    // R3: writes outside the window
    wr('h8000, 'h37); wr('h5FFF, 'h37); wr('hE001, 'hFF); wr('h4020, 'h37);
    sweep("R3", 0, 0);

    // R9: outputs hold old value until closing edge
    prg_inner = 8'h05;
    @(negedge clk);
    cpu_wr = 1; cpu_addr = 16'h6000; cpu_wdata = 8'h10;
    #1 chk("R9", int'(prg_bank), 'h005);
    @(negedge clk); cpu_wr = 0;
    #1 chk("R9", int'(prg_bank), exp_prg('h10, 0, 5));

    // R4: forwarding flag
    ram_en = 1;
    @(negedge clk); cpu_wr = 1; cpu_addr = 16'h7FFE; cpu_wdata = 8'h10;
    #1 chk("R4", int'(wram_wr), 1);
    ram_en = 0; #1 chk("R4", int'(wram_wr), 0);
    ram_en = 1; cpu_addr = 16'h8000; #1 chk("R4", int'(wram_wr), 0);
    cpu_addr = 16'h5FFF; #1 chk("R4", int'(wram_wr), 0);
    cpu_wr = 0; cpu_addr = 16'h6000; #1 chk("R4", int'(wram_wr), 0);

    // R2: 0x90 does not freeze
    wr('h6003, 'h90);
    wr('h6000, 'h20);
    sweep("R2", 'h20, 0);
    // the 0x80 write itself lands, then frozen
    wr('h6003, 'h80);
    wr('h6000, 'h30);
    sweep("R2", 'h20, 0);
    // frozen write still forwarded to RAM (collision)
    @(negedge clk); cpu_wr = 1; cpu_addr = 16'h6001; cpu_wdata = 8'hFF; ram_en = 1;
    #1 chk("R4", int'(wram_wr), 1);
    ram_en = 0; #1 chk("R4", int'(wram_wr), 0);
    @(negedge clk); cpu_wr = 0;
    sweep("R2", 'h20, 0);
    // unfreeze attempt via reg3 is dropped
    wr('h6003, 'h00);
    wr('h6000, 'h00);
    sweep("R2", 'h20, 0);

    // R8: reset clears freeze and registers
    do_reset();
    sweep("R8", 0, 0);
    wr('h6000, 'h88);
    sweep("R8", 'h88, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule